// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block serializes bytes onto an asynchronous serial line. A CPU-side write port hands it a data word and an optional ninth bit. A shift stage sends each frame one bit per baud tick, and the tick comes from an external rate generator. A one-entry holding register can sit in front of the shift stage. When that register is enabled, software can queue the next word while the current frame is still on the line. When it is disabled, the block acts as a plain single-buffered transmitter.

A control input selects when the sticky transmit interrupt flag is raised: either as the stop bit starts, or as it ends. A write that finds no room is discarded and raises a sticky overrun flag. Both flags stay set until their own clear input is pulsed.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset `txd` is high and `tx_irq` and `tx_ovr` are low. The line stays high whenever no frame is being sent.
- R2: With `frame9`=0 a frame lasts 10 baud-tick intervals. It is a low start bit, then the data bits least significant first, then a high stop bit. Each bit lasts from one `baud_tick` to the next.
- R3: With `frame9`=1 a frame lasts 11 intervals, and the `wr_ninth` value captured with the write is sent between the last data bit and the stop bit. With `frame9`=0 the `wr_ninth` value is never sent.
- R4: With `dbuf_en`=0, a write is taken only when no frame is waiting or being sent. Any other write is discarded and sets `tx_ovr`.
- R5: With `dbuf_en`=1, a write made while a frame is shifting is taken if the holding register is empty. That word is sent after the current frame.
- R6: If a word is waiting when a stop bit ends, its start bit begins on that same tick, with no idle interval.
- R7: A write that arrives while the holding register is full and the shift stage is busy is discarded. `tx_ovr` is high from the next clock. The discarded word never appears on the line.
- R8: With `irq_late`=0, `tx_irq` goes high at the clock edge where the stop bit begins.
- R9: With `irq_late`=1, `tx_irq` goes high at the clock edge where the stop bit ends.
- R10: `tx_irq` and `tx_ovr` stay high until a one-clock pulse on `irq_clr` or `ovr_clr` respectively clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-clock pulse per bit interval |
| wr_en | input | 1 | Write strobe for the data word |
| wr_data | input | DATA_W | Data word to send |
| wr_ninth | input | 1 | Ninth bit sent in 11-bit frames |
| frame9 | input | 1 | 1 selects 11-bit frames, 0 selects 10-bit frames |
| dbuf_en | input | 1 | 1 enables the holding register |
| irq_late | input | 1 | 0: flag at stop-bit start, 1: flag at stop-bit end |
| irq_clr | input | 1 | Clears `tx_irq` |
| ovr_clr | input | 1 | Clears `tx_ovr` |
| txd | output | 1 | Serial line, idles high |
| tx_irq | output | 1 | Sticky transmit interrupt flag |
| tx_ovr | output | 1 | Sticky overrun flag |

## Verification
A write accepted at clock edge E sits in the holding register after E and moves into the shift stage after E+1. The start bit then appears on the first tick edge from E+2 onward. Every later bit changes on the clock edge that samples a tick. The interrupt and overrun flags are registered at the same edge as the event that sets them, so they are visible one clock after the causing write or tick. The bench records `txd` and `tx_irq` at the falling edge after each tick edge, then decodes frames, gaps and flag timing from those records. Every expectation is therefore tied to a bit interval rather than to a guessed cycle count.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   typedef enum logic [1:0] {
      SH_IDLE  = 2'd0,
      SH_ARMED = 2'd1,
      SH_SEND  = 2'd2
   } sh_state_t;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_ninth,
   input  logic              dbuf_en,
   input  logic              sh_idle,
   input  logic              take,
   output logic              buf_valid,
   output logic [DATA_W-1:0] buf_data,
   output logic              buf_ninth,
   output logic              wr_drop
);
   logic accept;

   // double mode: room if empty or draining this cycle; single mode: whole path idle
   always_comb begin
      if (dbuf_en) accept = wr_en && (!buf_valid || take);
      else         accept = wr_en && sh_idle && !buf_valid;
   end
   assign wr_drop = wr_en && !accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_valid <= 1'b0;
         buf_data  <= '0;
         buf_ninth <= 1'b0;
      end else if (accept) begin
         buf_valid <= 1'b1;
         buf_data  <= wr_data;
         buf_ninth <= wr_ninth;
      end else if (take) begin
         buf_valid <= 1'b0;
      end
   end

   // R5
   queued_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dbuf_en && !sh_idle && !buf_valid) |=> buf_valid);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit NINTH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              frame9,
   input  logic              nxt_valid,
   input  logic [DATA_W-1:0] nxt_data,
   input  logic              nxt_ninth,
   output logic              take,
   output logic              sh_idle,
   output logic              stop_start,
   output logic              stop_end,
   output logic              txd_o
);
   localparam int FRAME_W = DATA_W + 2 + (NINTH_EN ? 1 : 0);
   localparam int CNT_W   = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
   localparam logic [CNT_W-1:0] LAST_SH  = CNT_W'(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_LG  = CNT_W'(FRAME_W - 1);

   sh_state_t           state;
   logic [FRAME_W-1:0]  sreg;
   logic [FRAME_W-1:0]  ld_vec;
   logic [CNT_W-1:0]    bit_cnt;
   logic [CNT_W-1:0]    last_idx;
   logic [CNT_W-1:0]    ld_last;
   logic                frame9_eff;

   generate
      if (NINTH_EN) begin : g_nine
         assign frame9_eff = frame9;
         assign ld_vec     = {1'b1, (frame9 ? nxt_ninth : 1'b1), nxt_data, 1'b0};
      end else begin : g_eight
         assign frame9_eff = 1'b0;
         assign ld_vec     = {1'b1, nxt_data, 1'b0};
      end
   endgenerate

   assign ld_last    = frame9_eff ? LAST_LG : LAST_SH;
   assign stop_start = (state == SH_SEND) && tick && (bit_cnt == last_idx - ONE);
   assign stop_end   = (state == SH_SEND) && tick && (bit_cnt == last_idx);
   assign take       = nxt_valid && ((state == SH_IDLE) || stop_end);
   assign sh_idle    = (state == SH_IDLE);
   assign txd_o      = (state == SH_SEND) ? sreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SH_IDLE;
         sreg     <= '1;
         bit_cnt  <= '0;
         last_idx <= LAST_SH;
      end else begin
         case (state)
            SH_IDLE: begin
               if (nxt_valid) begin
                  sreg     <= ld_vec;
                  last_idx <= ld_last;
                  state    <= SH_ARMED;
               end
            end
            SH_ARMED: begin
               if (tick) begin
                  state   <= SH_SEND;
                  bit_cnt <= '0;
               end
            end
            SH_SEND: begin
               if (tick) begin
                  if (bit_cnt == last_idx) begin
                     if (nxt_valid) begin
                        sreg     <= ld_vec;
                        last_idx <= ld_last;
                        bit_cnt  <= '0;
                     end else begin
                        state <= SH_IDLE;
                     end
                  end else begin
                     sreg    <= {1'b1, sreg[FRAME_W-1:1]};
                     bit_cnt <= bit_cnt + ONE;
                  end
               end
            end
            default: state <= SH_IDLE;
         endcase
      end
   end

   // R2
   stop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_start |=> txd_o);

   // R6
   no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_end && nxt_valid) |=> !txd_o);
endmodule

// File: rtl/sertx_flags.sv
module sertx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_late,
   input  logic stop_start,
   input  logic stop_end,
   input  logic irq_clr,
   input  logic drop,
   input  logic ovr_clr,
   output logic tx_irq,
   output logic tx_ovr
);
   logic irq_set;
   assign irq_set = irq_late ? stop_end : stop_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_irq <= 1'b0;
         tx_ovr <= 1'b0;
      end else begin
         tx_irq <= irq_set | (tx_irq & ~irq_clr);
         tx_ovr <= drop    | (tx_ovr & ~ovr_clr);
      end
   end

   // R10
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_irq && !irq_clr) |=> tx_irq);

   // R10
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovr && !ovr_clr) |=> tx_ovr);
endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf #(
   parameter int DATA_W   = 8,
   parameter bit NINTH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_ninth,
   input  logic              frame9,
   input  logic              dbuf_en,
   input  logic              irq_late,
   input  logic              irq_clr,
   input  logic              ovr_clr,
   output logic              txd,
   output logic              tx_irq,
   output logic              tx_ovr
);
   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("sertx_dbuf: DATA_W must lie in 5..9");
      end
   endgenerate

   logic              buf_valid;
   logic [DATA_W-1:0] buf_data;
   logic              buf_ninth;
   logic              wr_drop;
   logic              take;
   logic              sh_idle;
   logic              stop_start;
   logic              stop_end;

   sertx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_ninth(wr_ninth), .dbuf_en(dbuf_en), .sh_idle(sh_idle), .take(take),
      .buf_valid(buf_valid), .buf_data(buf_data), .buf_ninth(buf_ninth),
      .wr_drop(wr_drop)
   );

   sertx_shift #(.DATA_W(DATA_W), .NINTH_EN(NINTH_EN)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .frame9(frame9),
      .nxt_valid(buf_valid), .nxt_data(buf_data), .nxt_ninth(buf_ninth),
      .take(take), .sh_idle(sh_idle), .stop_start(stop_start),
      .stop_end(stop_end), .txd_o(txd)
   );

   sertx_flags u_flags (
      .clk(clk), .rst_n(rst_n), .irq_late(irq_late), .stop_start(stop_start),
      .stop_end(stop_end), .irq_clr(irq_clr), .drop(wr_drop), .ovr_clr(ovr_clr),
      .tx_irq(tx_irq), .tx_ovr(tx_ovr)
   );

   // R7
   drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_drop |=> tx_ovr);

   // R8
   early_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_late && stop_start) |=> tx_irq);

   // R9
   late_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_late && stop_end) |=> tx_irq);
endmodule

// File: tb/sertx_dbuf_tb.sv
module sertx_dbuf_tb;
   localparam int DW  = 8;
   localparam int REC = 16384;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick = 1'b0;
   logic wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic wr_ninth = 1'b0;
   logic frame9 = 1'b0;
   logic dbuf_en = 1'b0;
   logic irq_late = 1'b0;
   logic irq_clr = 1'b0;
   logic ovr_clr = 1'b0;
   logic txd, tx_irq, tx_ovr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic rec_bit [0:REC-1];
   logic rec_irq [0:REC-1];
   int   rec_n = 0;
   logic tick_q = 1'b0;

   sertx_dbuf #(.DATA_W(DW), .NINTH_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
      .wr_data(wr_data), .wr_ninth(wr_ninth), .frame9(frame9),
      .dbuf_en(dbuf_en), .irq_late(irq_late), .irq_clr(irq_clr),
      .ovr_clr(ovr_clr), .txd(txd), .tx_irq(tx_irq), .tx_ovr(tx_ovr)
   );

   always #10 clk = ~clk;

   initial begin
      forever begin
         repeat (3) @(negedge clk);
         baud_tick = 1'b1;
         @(negedge clk);
         baud_tick = 1'b0;
      end
   end

   always @(posedge clk) tick_q <= baud_tick;

   always @(negedge clk) begin
      if (tick_q && rec_n < REC) begin
         rec_bit[rec_n] = txd;
         rec_irq[rec_n] = tx_irq;
         rec_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   endtask

   function automatic logic [7:0] pat(input int i);
      case (i)
         0: pat = 8'h00;
         1: pat = 8'hFF;
         2: pat = 8'hA5;
         3: pat = 8'h5A;
         4: pat = 8'h01;
         default: pat = 8'h80;
      endcase
   endfunction

   function automatic int find_start(input int from);
      find_start = -1;
      for (int i = from; i < rec_n; i++) begin
         if (rec_bit[i] == 1'b0) begin
            find_start = i;
            break;
         end
      end
   endfunction

   task automatic wr(input logic [7:0] d, input logic b9);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d; wr_ninth = b9;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_irq_clr();
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
   endtask

   task automatic pulse_ovr_clr();
      @(negedge clk); ovr_clr = 1'b1;
      @(negedge clk); ovr_clr = 1'b0;
   endtask

   // decodes a frame starting at record index s
   task automatic check_frame(input int s, input logic [7:0] d, input logic b9, input bit f9);
      logic [7:0] got;
      int nb;
      nb = f9 ? 11 : 10;
      for (int k = 0; k < 8; k++) got[k] = rec_bit[s+1+k];
      chk(got == d, "R2 data bits lsb first", int'(got), int'(d));
      if (f9) chk(rec_bit[s+9] == b9, "R3 ninth bit", int'(rec_bit[s+9]), int'(b9));
      chk(rec_bit[s+nb-1] == 1'b1, "R2 R3 stop bit high", int'(rec_bit[s+nb-1]), 1);
   endtask

   task automatic check_idle(input int from, input string req);
      int zeros;
      zeros = 0;
      for (int i = from; i < rec_n; i++) if (rec_bit[i] == 1'b0) zeros++;
      chk(zeros == 0, req, zeros, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_up();
   end

   initial begin
      int base, s, s2, nb;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
      chk(tx_irq == 1'b0, "R1 tx_irq after reset", int'(tx_irq), 0);
      chk(tx_ovr == 1'b0, "R1 tx_ovr after reset", int'(tx_ovr), 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(txd == 1'b1, "R1 idle line", int'(txd), 1);

      // sweep: frame size x buffer mode x irq point x data patterns
      for (int cfg = 0; cfg < 8; cfg++) begin
         for (int v = 0; v < 6; v++) begin
            logic [7:0] d;
            logic b9;
            d  = pat(v);
            b9 = v[0];
            @(negedge clk);
            frame9 = cfg[0]; dbuf_en = cfg[1]; irq_late = cfg[2];
            nb = cfg[0] ? 11 : 10;
            pulse_irq_clr();
            base = rec_n;
            wr(d, b9);
            repeat ((nb + 4) * 4 + 6) @(negedge clk);
            s = find_start(base);
            chk(s >= 0, "R2 start bit seen", s, base);
            if (s >= 0) begin
               check_frame(s, d, b9, cfg[0]);
               check_idle(s + nb, cfg[0] ? "R3 eleven bit length" : "R2 R3 ten bit length");
               if (cfg[2]) begin
                  chk(rec_irq[s+nb-1] == 1'b0, "R9 no flag during stop", int'(rec_irq[s+nb-1]), 0);
                  chk(rec_irq[s+nb] == 1'b1, "R9 flag at stop end", int'(rec_irq[s+nb]), 1);
               end else begin
                  chk(rec_irq[s+nb-2] == 1'b0, "R8 no flag before stop", int'(rec_irq[s+nb-2]), 0);
                  chk(rec_irq[s+nb-1] == 1'b1, "R8 flag at stop start", int'(rec_irq[s+nb-1]), 1);
               end
               chk(tx_irq == 1'b1, "R10 flag held", int'(tx_irq), 1);
            end
            chk(tx_ovr == 1'b0, "R4 R5 write accepted", int'(tx_ovr), 0);
         end
      end

      // R10 clearing
      pulse_irq_clr();
      chk(tx_irq == 1'b0, "R10 irq clear", int'(tx_irq), 0);

      // R5 R6 second write queued during a frame
      for (int f = 0; f < 2; f++) begin
         @(negedge clk);
         frame9 = f[0]; dbuf_en = 1'b1; irq_late = 1'b0;
         nb = f[0] ? 11 : 10;
         base = rec_n;
         wr(8'h3C, 1'b1);
         repeat (12) @(negedge clk);
         wr(8'hC3, 1'b0);
         repeat ((2 * nb + 4) * 4 + 8) @(negedge clk);
         s = find_start(base);
         chk(s >= 0, "R5 first frame seen", s, base);
         if (s >= 0) begin
            check_frame(s, 8'h3C, 1'b1, f[0]);
            s2 = find_start(s + nb);
            chk(s2 == s + nb, "R6 back to back start", s2, s + nb);
            if (s2 >= 0) begin
               check_frame(s2, 8'hC3, 1'b0, f[0]);
               check_idle(s2 + nb, "R5 line idle after queue");
            end
         end
         chk(tx_ovr == 1'b0, "R5 no overrun", int'(tx_ovr), 0);
      end

      // R7 third write while holding full and shifter armed
      @(negedge clk);
      frame9 = 1'b0; dbuf_en = 1'b1;
      base = rec_n;
      wr_en = 1'b1; wr_data = 8'h11; wr_ninth = 1'b0;
      @(negedge clk); wr_data = 8'h22;
      @(negedge clk); wr_data = 8'h00;
      @(negedge clk); wr_en = 1'b0;
      chk(tx_ovr == 1'b1, "R7 overrun set", int'(tx_ovr), 1);
      repeat (26 * 4 + 8) @(negedge clk);
      s = find_start(base);
      chk(s >= 0, "R7 first frame seen", s, base);
      if (s >= 0) begin
         check_frame(s, 8'h11, 1'b0, 1'b0);
         s2 = find_start(s + 10);
         chk(s2 == s + 10, "R7 second frame follows", s2, s + 10);
         if (s2 >= 0) begin
            check_frame(s2, 8'h22, 1'b0, 1'b0);
            check_idle(s2 + 10, "R7 dropped word not sent");
         end
      end
      chk(tx_ovr == 1'b1, "R10 overrun held", int'(tx_ovr), 1);
      pulse_ovr_clr();
      chk(tx_ovr == 1'b0, "R10 overrun clear", int'(tx_ovr), 0);

      // R4 single buffer: write during a frame is dropped
      @(negedge clk);
      dbuf_en = 1'b0;
      base = rec_n;
      wr(8'h96, 1'b0);
      repeat (8) @(negedge clk);
      wr(8'h00, 1'b0);
      chk(tx_ovr == 1'b1, "R4 busy write dropped", int'(tx_ovr), 1);
      repeat (24 * 4) @(negedge clk);
      s = find_start(base);
      chk(s >= 0, "R4 frame seen", s, base);
      if (s >= 0) begin
         check_frame(s, 8'h96, 1'b0, 1'b0);
         check_idle(s + 10, "R4 dropped word not sent");
      end
      pulse_ovr_clr();
      chk(txd == 1'b1, "R1 idle at end", int'(txd), 1);
      finish_up();
   end
endmodule